// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block pairs an 8-bit timer/counter with a watchdog timer. The two share one power-of-two prescaler, and a select bit in the control register hands that prescaler to exactly one of them. The clock is treated as the oscillator. A free-running phase counter splits it into four-phase instruction cycles and produces one instruction tick per cycle.

The timer counts either instruction ticks or rising edges of an external clock input. The external input passes through a synchronizer, and the prescaler output is then sampled on the second and fourth phases of each instruction cycle. An 8-bit watchdog base counter runs on the instruction tick, and its wrap-around drives a one-cycle timeout (reset request) output.

Software manages the prescaler. A timer write clears it while it belongs to the timer, and a watchdog clear strobe clears it while it belongs to the watchdog. Moving the select bit does neither, so a careless reassignment can cause an early timeout.

Top module: `shared_presc_timer`

## Requirements
- R1: After reset the timer reads 00h and the overflow flag, interrupt request and timeout output are all low. The control register resets to: prescaler on the watchdog, rate field 111b, internal tick source, interrupt enable off.
- R2: With the select bit at 0 and the internal source, the timer advances once per 2^(n+1) instruction ticks counted from the last prescaler clear, where n is the rate field. Each instruction tick falls on phase 3 of the four-clock cycle that follows reset.
- R3: With the select bit at 1, the timer advances on every instruction tick (1:1). The watchdog then divides base-counter wraps by 2^n.
- R4: A timer write loads the written value. It clears the prescaler only while the select bit is 0.
- R5: A watchdog clear zeroes the base counter. It clears the prescaler only while the select bit is 1, and no timeout follows it on the next cycle.
- R6: A timer step from FFh to 00h sets the overflow flag whether or not interrupts are enabled. The flag stays set until the flag-clear strobe, and a set in the same cycle as a clear wins.
- R7: The interrupt request equals the overflow flag ANDed with the interrupt enable bit.
- R8: While the sleep input is high the timer and a timer-assigned prescaler are frozen, while the watchdog keeps counting and can still time out.
- R9: The timeout output pulses high for one cycle on the clock after the instruction tick at which the base counter wraps from FFh with the prescaler (when assigned) at its terminal count.
- R10: Changing the select bit leaves the prescaler count untouched. A count left over from timer use therefore shortens the first watchdog period after reassignment.
- R11: With the external source selected, the timer counts synchronized rising edges of the external clock input, divided per R2/R3. Each prescaler output event is applied to the timer on the next phase 1 or phase 3 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count input, asynchronous |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdt_sel_i | input | 1 | Prescaler select: 0 timer, 1 watchdog |
| ctl_rate_i | input | 3 | Prescaler rate field |
| ctl_ext_src_i | input | 1 | Timer source: 0 instruction tick, 1 external input |
| ctl_irq_en_i | input | 1 | Overflow interrupt enable |
| tmr_we_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | 8 | Timer write data |
| tmr_o | output | 8 | Timer value |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| sleep_i | input | 1 | Sleep state input |
| wdt_rst_o | output | 1 | Watchdog timeout pulse |

## Verification
The hidden prescaler count can only be seen in how far apart timer steps and timeouts fall. A wrong count shows up at the next timer step, at most 2^(n+1) ticks later, as a timer value off by one. On the watchdog side it shows up as a timeout hundreds of ticks early or late. The per-clock reference model catches these differences at the first cycle they occur. Mid-count timer writes and a deliberately unsafe reassignment push stale counts to the outputs.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int unsigned RATE_W = 3;

  typedef struct packed {
    logic              wdt_sel;
    logic [RATE_W-1:0] rate;
    logic              ext_src;
    logic              irq_en;
  } ctl_t;

  localparam ctl_t CTL_RST = '{wdt_sel: 1'b1, rate: {RATE_W{1'b1}},
                               ext_src: 1'b0, irq_en: 1'b0};
endpackage

// File: rtl/tps_phase.sv
module tps_phase #(
  parameter int unsigned PH_W        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic tick_o,
  output logic sample_o,
  output logic ext_rise_o
);
  logic [PH_W-1:0]        ph_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_q + PH_W'(1);
  end

  // last phase ends the instruction cycle; odd phases sample external events
  assign tick_o   = &ph_q;
  assign sample_o = ph_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdt_sel_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              tmr_evt_i,
  input  logic              sleep_i,
  input  logic              wdt_ovf_i,
  input  logic              tmr_wr_i,
  input  logic              wdt_clr_i,
  output logic              tmr_pulse_o,
  output logic              wdt_to_o
);
  logic [PRE_W-1:0] cnt_q, mask_t, mask_w;
  logic             hit_t, hit_w, cnt_inc, cnt_clr;

  // timer ratio 2^(n+1), watchdog ratio 2^n; shifts wrap to all-ones at the top
  assign mask_t = (PRE_W'(2) << rate_i) - PRE_W'(1);
  assign mask_w = (PRE_W'(1) << rate_i) - PRE_W'(1);
  assign hit_t  = (cnt_q & mask_t) == mask_t;
  assign hit_w  = (cnt_q & mask_w) == mask_w;

  assign cnt_inc = wdt_sel_i ? wdt_ovf_i : (tmr_evt_i & ~sleep_i);
  assign cnt_clr = wdt_sel_i ? wdt_clr_i : tmr_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_q + PRE_W'(1);
  end

  assign tmr_pulse_o = wdt_sel_i ? tmr_evt_i : (tmr_evt_i & ~sleep_i & hit_t);
  assign wdt_to_o    = wdt_sel_i ? (wdt_ovf_i & hit_w) : wdt_ovf_i;
endmodule

// File: rtl/tps_wdt.sv
module tps_wdt #(
  parameter int unsigned WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic to_i,
  output logic ovf_o,
  output logic rst_o
);
  logic [WDT_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (clr_i)  base_q <= '0;
    else if (tick_i) base_q <= base_q + WDT_W'(1);
  end

  assign ovf_o = tick_i & (&base_q) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_o <= 1'b0;
    else         rst_o <= to_i;
  end
endmodule

// File: rtl/tps_timer.sv
module tps_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_src_i,
  input  logic             sample_i,
  input  logic             pulse_i,
  input  logic             sleep_i,
  input  logic             we_i,
  input  logic [TMR_W-1:0] wdata_i,
  input  logic             flag_clr_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             flag_o
);
  logic pend_q, take, inc, wrap;

  // external events wait for an odd phase before reaching the counter
  assign take = ext_src_i & sample_i & pend_q & ~sleep_i;
  assign inc  = ext_src_i ? take : (pulse_i & ~sleep_i);
  assign wrap = inc & (&tmr_o) & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (!ext_src_i) pend_q <= 1'b0;
    else                 pend_q <= pulse_i | (pend_q & ~take);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tmr_o <= '0;
    else if (we_i) tmr_o <= wdata_i;
    else if (inc)  tmr_o <= tmr_o + TMR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (wrap)       flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/shared_presc_timer.sv
module shared_presc_timer
  import tps_pkg::*;
#(
  parameter int unsigned TMR_W       = 8,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned WDT_W       = 8,
  parameter int unsigned PH_W        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              ctl_we_i,
  input  logic              ctl_wdt_sel_i,
  input  logic [RATE_W-1:0] ctl_rate_i,
  input  logic              ctl_ext_src_i,
  input  logic              ctl_irq_en_i,
  input  logic              tmr_we_i,
  input  logic [TMR_W-1:0]  tmr_wdata_i,
  output logic [TMR_W-1:0]  tmr_o,
  input  logic              ovf_clr_i,
  output logic              ovf_flag_o,
  output logic              irq_o,
  input  logic              wdt_clr_i,
  input  logic              sleep_i,
  output logic              wdt_rst_o
);
  ctl_t ctl_q;
  logic tick, sample, ext_rise, tmr_evt, tmr_pulse, wdt_ovf, wdt_to;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= CTL_RST;
    else if (ctl_we_i) ctl_q <= '{wdt_sel: ctl_wdt_sel_i, rate: ctl_rate_i,
                                  ext_src: ctl_ext_src_i, irq_en: ctl_irq_en_i};
  end

  tps_phase #(.PH_W(PH_W), .SYNC_STAGES(SYNC_STAGES)) i_phase (
    .clk_i, .rst_ni, .ext_i(ext_clk_i),
    .tick_o(tick), .sample_o(sample), .ext_rise_o(ext_rise)
  );

  assign tmr_evt = ctl_q.ext_src ? ext_rise : tick;

  tps_prescaler #(.PRE_W(PRE_W), .RATE_W(RATE_W)) i_presc (
    .clk_i, .rst_ni,
    .wdt_sel_i(ctl_q.wdt_sel), .rate_i(ctl_q.rate),
    .tmr_evt_i(tmr_evt), .sleep_i, .wdt_ovf_i(wdt_ovf),
    .tmr_wr_i(tmr_we_i), .wdt_clr_i,
    .tmr_pulse_o(tmr_pulse), .wdt_to_o(wdt_to)
  );

  tps_wdt #(.WDT_W(WDT_W)) i_wdt (
    .clk_i, .rst_ni, .tick_i(tick), .clr_i(wdt_clr_i), .to_i(wdt_to),
    .ovf_o(wdt_ovf), .rst_o(wdt_rst_o)
  );

  tps_timer #(.TMR_W(TMR_W)) i_timer (
    .clk_i, .rst_ni, .ext_src_i(ctl_q.ext_src), .sample_i(sample),
    .pulse_i(tmr_pulse), .sleep_i, .we_i(tmr_we_i), .wdata_i(tmr_wdata_i),
    .flag_clr_i(ovf_clr_i), .tmr_o, .flag_o(ovf_flag_o)
  );

  assign irq_o = ovf_flag_o & ctl_q.irq_en;
endmodule

// File: rtl/shared_presc_timer_chk.sv
module shared_presc_timer_chk #(
  parameter int unsigned TMR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TMR_W-1:0] tmr_o,
  input logic             tmr_we_i,
  input logic             ovf_flag_o,
  input logic             ovf_clr_i,
  input logic             irq_o,
  input logic             sleep_i,
  input logic             wdt_clr_i,
  input logic             wdt_rst_o
);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_we_i |=> (tmr_o == $past(tmr_o) || tmr_o == $past(tmr_o) + TMR_W'(1)));

  p_clr_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |=> !wdt_rst_o);

  p_flag_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> ($past(tmr_o) == {TMR_W{1'b1}} && tmr_o == '0));

  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_flag_o);

  p_sleep_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !tmr_we_i) |=> $stable(tmr_o));

  p_rst_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
endmodule

bind shared_presc_timer shared_presc_timer_chk #(.TMR_W(TMR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tmr_o(tmr_o), .tmr_we_i(tmr_we_i),
  .ovf_flag_o(ovf_flag_o), .ovf_clr_i(ovf_clr_i), .irq_o(irq_o),
  .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i), .wdt_rst_o(wdt_rst_o)
);

// File: tb/test_shared_presc_timer.sv
module test_shared_presc_timer;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ext_clk = 0, ctl_we = 0, ctl_sel = 0, ctl_ext = 0, ctl_ie = 0;
  logic [2:0] ctl_rate = 0;
  logic       tmr_we = 0, ovf_clr = 0, wdt_clr = 0, sleep = 0;
  logic [7:0] tmr_wdata = 0;
  logic [7:0] tmr;
  logic       flag, irq, wdt_rst;

  int compared = 0, mismatched = 0, cycles = 0;
  bit skip_tmr = 0, done = 0;

  // reference state
  int m_ph, m_sel, m_rate, m_ext, m_ie, m_pre, m_tmr, m_flag, m_base, m_rst;

  always #2.5 clk = ~clk;

  shared_presc_timer i_shared_presc_timer (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk),
    .ctl_we_i(ctl_we), .ctl_wdt_sel_i(ctl_sel), .ctl_rate_i(ctl_rate),
    .ctl_ext_src_i(ctl_ext), .ctl_irq_en_i(ctl_ie),
    .tmr_we_i(tmr_we), .tmr_wdata_i(tmr_wdata), .tmr_o(tmr),
    .ovf_clr_i(ovf_clr), .ovf_flag_o(flag), .irq_o(irq),
    .wdt_clr_i(wdt_clr), .sleep_i(sleep), .wdt_rst_o(wdt_rst)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_sel = 1; m_rate = 7; m_ext = 0; m_ie = 0;
      m_pre = 0; m_tmr = 0; m_flag = 0; m_base = 0; m_rst = 0;
    end else begin
      bit tick, evt, wovf, lw, lt, tmo, tinc, pinc, pclr;
      int mw, mt;
      tick = (m_ph == 3);
      evt  = (m_ext == 0) && tick;
      wovf = tick && m_base == 255 && !wdt_clr;
      mw   = (1 << m_rate) - 1;
      mt   = ((2 << m_rate) - 1) & 255;
      lw   = (m_pre & mw) == mw;
      lt   = (m_pre & mt) == mt;
      tmo  = wovf && (m_sel == 0 || lw);
      tinc = !sleep && evt && (m_sel == 1 || lt);
      pinc = (m_sel == 1) ? wovf : (evt && !sleep);
      pclr = (m_sel == 0) ? tmr_we : wdt_clr;
      if (tinc && m_tmr == 255 && !tmr_we) m_flag = 1;
      else if (ovf_clr) m_flag = 0;
      if (pclr) m_pre = 0; else if (pinc) m_pre = (m_pre + 1) & 255;
      if (tmr_we) m_tmr = tmr_wdata; else if (tinc) m_tmr = (m_tmr + 1) & 255;
      if (wdt_clr) m_base = 0; else if (tick) m_base = (m_base + 1) & 255;
      m_rst = tmo;
      if (ctl_we) begin
        m_sel = ctl_sel; m_rate = ctl_rate; m_ext = ctl_ext; m_ie = ctl_ie;
      end
      m_ph = (m_ph + 1) & 3;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit bad;
      bad = 0;
      compared++;
      if (!skip_tmr && tmr !== 8'(m_tmr)) begin
        bad = 1; $display("FAIL R2 tmr actual %0h expected %0h t=%0t", tmr, m_tmr, $time);
      end
      if (!skip_tmr && flag !== 1'(m_flag)) begin
        bad = 1; $display("FAIL R6 flag actual %0b expected %0b t=%0t", flag, m_flag, $time);
      end
      if (!skip_tmr && irq !== 1'(m_flag & m_ie)) begin
        bad = 1; $display("FAIL R7 irq actual %0b expected %0b t=%0t", irq, m_flag & m_ie, $time);
      end
      if (wdt_rst !== 1'(m_rst)) begin
        bad = 1; $display("FAIL R9 wdt_rst actual %0b expected %0b t=%0t", wdt_rst, m_rst, $time);
      end
      if (bad) mismatched++;
    end
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(bit sel, bit [2:0] rate, bit ext, bit ie);
    @(negedge clk);
    ctl_we = 1; ctl_sel = sel; ctl_rate = rate; ctl_ext = ext; ctl_ie = ie;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic tmr_write(bit [7:0] v, bit also_wclr = 0);
    @(negedge clk);
    tmr_we = 1; tmr_wdata = v; wdt_clr = also_wclr;
    @(negedge clk);
    tmr_we = 0; wdt_clr = 0;
  endtask

  task automatic pulse_wclr();
    @(negedge clk); wdt_clr = 1;
    @(negedge clk); wdt_clr = 0;
  endtask

  task automatic pulse_fclr();
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
  endtask

  task automatic ext_edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1; idle(8);
      ext_clk = 0; idle(8);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired actual %0d expected below 150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int n, cnt;
    idle(3);
    // R1 reset state
    check("R1 tmr", tmr, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);
    check("R1 wdt_rst", wdt_rst, 0);
    @(negedge clk) rst_n = 1;

    // R3 default: 1:1 timer while watchdog owns the prescaler
    idle(20);
    tmr_write(8'h00);
    idle(40);
    check("R3 tmr after 10 ticks", tmr, 10);

    // R4 mid-count write clears the timer-owned prescaler
    ctl_write(0, 3'd1, 0, 0);
    tmr_write(8'h00);
    idle(12);
    tmr_write(8'h00);
    idle(52);
    check("R4 tmr after cleared prescaler", tmr, 3);

    // R6/R7 overflow with interrupt disabled, then enabled
    ctl_write(0, 3'd0, 0, 0);
    tmr_write(8'hF8);
    idle(100);
    check("R6 flag set on wrap", flag, 1);
    check("R7 irq masked", irq, 0);
    ctl_write(0, 3'd0, 0, 1);
    check("R7 irq enabled", irq, 1);
    pulse_fclr();
    check("R6 flag cleared", flag, 0);

    // R8 sleep freezes timer
    tmr_write(8'h10);
    sleep = 1;
    idle(40);
    check("R8 tmr frozen", tmr, 8'h10);
    sleep = 0;

    // R3/R9/R8 watchdog 1:1, keeps running in sleep
    ctl_write(1, 3'd0, 0, 0);
    pulse_wclr();
    sleep = 1;
    cnt = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (wdt_rst) cnt++;
    end
    sleep = 0;
    check("R8 timeouts during sleep", cnt, 1);

    // R10 reassignment without clearing: stale count 7 with 1:8
    ctl_write(0, 3'd3, 0, 0);
    tmr_write(8'h00, 1);
    idle(26);
    ctl_write(1, 3'd3, 0, 0);
    n = 0;
    while (!wdt_rst && n < 3000) begin
      @(negedge clk); n++;
    end
    check("R10 early timeout seen", (n < 1100) ? 1 : 0, 1);

    // R5 proper clear gives full 2048-tick period
    pulse_wclr();
    n = 0;
    while (!wdt_rst && n < 9000) begin
      @(negedge clk); n++;
    end
    check("R5 full period after clear", (n >= 8180 && n <= 8200) ? 1 : 0, 1);

    // R11 external source, 1:1 then 1:4
    skip_tmr = 1;
    ctl_write(1, 3'd0, 1, 0);
    tmr_write(8'h00);
    ext_edges(5);
    idle(20);
    check("R11 ext 1:1 count", tmr, 5);
    ctl_write(0, 3'd1, 1, 0);
    tmr_write(8'h00);
    ext_edges(8);
    idle(20);
    check("R11 ext 1:4 count", tmr, 2);
    ctl_write(0, 3'd1, 0, 0);
    tmr_write(8'h00);
    skip_tmr = 0;
    idle(40);

    finish_run();
  end
endmodule